// File: doc/BRIEF.md
# Two-Input Lookup Logic Fabric

A compact configurable logic fabric of 32 small logic elements arranged as four groups of eight. Each element evaluates a user-chosen Boolean function of two inputs through a four-entry truth table. It can present that result either straight through or after one clock of delay. Element inputs come from fixed routing: neighbours within the same group, a feedback ring between groups, GPIO pins, software-set data bits, or, for the upper two groups, the output of the matching element in the lower half.

Software programs every element through a plain address/data port. Each element has its own 11-bit setup word. One further address holds a 16-bit data word that feeds the lower half. Another address returns every element output at once as a 32-bit word. Fourteen GPIO outputs are driven by elements 16 to 29.

Top module: `lut_fabric`

## Requirements
- R1: After reset every setup word, the data word and every element state are 0, so all 32 element outputs, all GPIO outputs and every read-back value are 0.
- R2: An element's function result is setup bit [1+{A,B}]: bit 1 for A=0,B=0, bit 2 for A=0,B=1, bit 3 for A=1,B=0, bit 4 for A=1,B=1.
- R3: Each element has a state flop that captures its function result on every clock. Setup bit 0 picks the output: 0 gives the function result in the same cycle, and 1 gives the state, i.e. the result from the previous clock.
- R4: With A-select (bits [10:9]) at 0, A is the state of element 0 of the element's own group. The exception is element 0 of group k, which takes the state of element 7 of group (k+3) mod 4.
- R5: With bit 5 set, B is the secondary source; with it clear, B comes from the B-select bits [8:7]. For elements 0 to 15, the secondary source is `gpio_in[n mod 14]` when bit 6 is 0, and bit n of the data word when bit 6 is 1.
- R6: For elements 16 to 31, the secondary source is the output of element n-16 when bit 6 is 0, and constant 0 when bit 6 is 1.
- R7: With B-select at 0 and bit 5 clear, B is the element's own state, so a registered inverter toggles on every clock.
- R8: A write to address 0 to 31 loads that element's setup word from `wdata[10:0]`. A write to address 32 loads the data word from `wdata[15:0]`. Writes to any other address change nothing. Reads return the setup word at 0 to 31, the data word at 32 and all element outputs at 33, zero-extended; any other address reads 0.
- R9: `gpio_out[i]` is the output of element 16+i.
- R10: When a setup word is written, the clock edge that writes it captures the element state with the old setup word; the new word applies from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 6 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| gpio_in | input | 14 | GPIO inputs to elements 0 to 15 |
| gpio_out | output | 14 | GPIO outputs from elements 16 to 29 |
| elem_out | output | 32 | Output of every element |

## Verification
A setup-word or data-word write can land on the same clock edge on which a registered element captures its function result. The bench provokes this by rewriting a constant-one registered element to constant zero. It also clears the data bit that a registered buffer follows, while that buffer is running. It then expects the output to keep the old value for exactly one cycle and to change on the next edge.

// File: rtl/lut_fabric.sv
module lut_fabric #(
  parameter int NGPIO = 14,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NGPIO-1:0] gpio_in,
  output logic [NGPIO-1:0] gpio_out,
  output logic [31:0]      elem_out
);
  localparam int NBLK = 4;
  localparam int NPB  = 8;
  localparam int NEL  = NBLK * NPB;
  localparam int HALF = NEL / 2;
  localparam int CW   = 11;
  localparam int IW   = $clog2(NEL);
  localparam logic [AW-1:0] A_DATA = AW'(NEL);
  localparam logic [AW-1:0] A_STAT = AW'(NEL + 1);

  logic [NEL-1:0][CW-1:0] cfg;
  logic [HALF-1:0]        data_q;
  logic [NEL-1:0]         q, lut;
  logic [HALF-1:0]        out_lo, out_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      if (addr < A_DATA) cfg[addr[IW-1:0]] <= wdata[CW-1:0];
      else if (addr == A_DATA) data_q <= wdata[HALF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= lut;
  end

  always_comb begin
    rdata = '0;
    if (addr < A_DATA)       rdata[CW-1:0]   = cfg[addr[IW-1:0]];
    else if (addr == A_DATA) rdata[HALF-1:0] = data_q;
    else if (addr == A_STAT) rdata[NEL-1:0]  = elem_out;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata[DW-1:HALF];

  for (genvar n = 0; n < NEL; n++) begin : g_el
    localparam int K    = n / NPB;
    localparam int J    = n % NPB;
    localparam int BASE = K * NPB;
    localparam int FB   = (J == 0) ? ((K + NBLK - 1) % NBLK) * NPB + NPB - 1 : BASE;
    logic       a_s, b_m, b_s, sec, f;
    logic [3:0] tt;

    always_comb begin
      case (cfg[n][10:9])
        2'd0:    a_s = q[FB];
        2'd1:    a_s = q[BASE + (J + 1) % NPB];
        2'd2:    a_s = q[BASE + (J + 2) % NPB];
        default: a_s = q[BASE + (J + 7) % NPB];
      endcase
      case (cfg[n][8:7])
        2'd0:    b_m = q[n];
        2'd1:    b_m = q[BASE + (J + 3) % NPB];
        2'd2:    b_m = q[BASE + (J + 4) % NPB];
        default: b_m = q[BASE + (J + 5) % NPB];
      endcase
    end

    if (n < HALF) begin : g_lo
      assign sec       = cfg[n][6] ? data_q[n] : gpio_in[n % NGPIO];
      assign out_lo[n] = cfg[n][0] ? q[n] : f;
    end else begin : g_hi
      assign sec              = cfg[n][6] ? 1'b0 : out_lo[n - HALF];
      assign out_hi[n - HALF] = cfg[n][0] ? q[n] : f;
    end

    assign b_s    = cfg[n][5] ? sec : b_m;
    assign tt     = cfg[n][4:1];
    assign f      = tt[{a_s, b_s}];
    assign lut[n] = f;
  end

  assign elem_out = {out_hi, out_lo};
  assign gpio_out = out_hi[NGPIO-1:0];
endmodule

// File: rtl/lut_fabric_chk.sv
module lut_fabric_chk #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [31:0][10:0] cfg,
  input logic [15:0]       data_q,
  input logic [31:0]       q,
  input logic [31:0]       lut,
  input logic [31:0]       elem_out
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (elem_out == '0));

  a_r8_data_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(32)) |=> (data_q == $past(wdata[15:0])));

  for (genvar n = 0; n < 32; n++) begin : g_a
    a_r8_cfg_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == AW'(n)) |=> (cfg[n] == $past(wdata[10:0])));

    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && addr == AW'(n)) |=> $stable(cfg[n]));

    a_r3_reg_delay: assert property (@(posedge clk) disable iff (rst)
      (cfg[n][0] && !$past(rst)) |-> (elem_out[n] == $past(lut[n])));

    a_r10_old_word_used: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == AW'(n)) |=> (q[n] == $past(lut[n])));
  end
endmodule

bind lut_fabric lut_fabric_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cfg(cfg), .data_q(data_q), .q(q), .lut(lut), .elem_out(elem_out)
);

// File: tb/lut_fabric_bench.sv
module lut_fabric_bench;
  logic        clk = 1'b0;
  logic        rst, wr_en;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata, elem_out;
  logic [13:0] gpio_in, gpio_out;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  lut_fabric u_lut_fabric (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gpio_in(gpio_in), .gpio_out(gpio_out), .elem_out(elem_out)
  );

  // {truth[4:1], A, B, expected}
  localparam logic [6:0] VEC [16] = '{
    7'b1000_00_0, 7'b1000_01_0, 7'b1000_10_0, 7'b1000_11_1,
    7'b0110_00_0, 7'b0110_01_1, 7'b0110_10_1, 7'b0110_11_0,
    7'b1110_00_0, 7'b1110_01_1, 7'b1110_10_1, 7'b1110_11_1,
    7'b0111_00_1, 7'b0111_01_1, 7'b0111_10_1, 7'b0111_11_0
  };

  function automatic logic [31:0] cw(input logic [1:0] as, input logic [1:0] bs,
                                     input logic s6, input logic s5,
                                     input logic [3:0] tt, input logic r);
    return {21'b0, as, bs, s6, s5, tt, r};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; gpio_in = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 elem_out", elem_out, 32'h0);
    chk("R1 gpio_out", {18'b0, gpio_out}, 32'h0);
    addr = 6'd5; #1 chk("R1 cfg read", rdata, 32'h0);
    addr = 6'd33; #1 chk("R1 status read", rdata, 32'h0);

    // element 0 buffers gpio_in[0]; element 1: A = state of element 0, B = gpio_in[1]
    wr(6'd0, cw(2'd0, 2'd0, 1'b0, 1'b1, 4'b1010, 1'b0));
    for (int i = 0; i < 16; i++) begin
      gpio_in[0] = VEC[i][2];
      gpio_in[1] = VEC[i][1];
      wr(6'd1, cw(2'd0, 2'd0, 1'b0, 1'b1, VEC[i][6:3], 1'b0));
      #1 chk($sformatf("R2 vec%0d", i), {31'b0, elem_out[1]}, {31'b0, VEC[i][0]});
    end

    // R4: element 3 takes element 0 state; element 8 takes element 7 state
    wr(6'd3, cw(2'd0, 2'd0, 1'b0, 1'b0, 4'b1100, 1'b0));
    gpio_in[0] = 1'b1; tick();
    chk("R4 group feedback", {31'b0, elem_out[3]}, 32'h1);
    gpio_in[0] = 1'b0; #1 chk("R4 feedback is state", {31'b0, elem_out[3]}, 32'h1);
    tick(); chk("R4 feedback follows", {31'b0, elem_out[3]}, 32'h0);
    wr(6'd7, cw(2'd0, 2'd0, 1'b0, 1'b1, 4'b1010, 1'b0));
    wr(6'd8, cw(2'd0, 2'd0, 1'b0, 1'b0, 4'b1100, 1'b0));
    gpio_in[7] = 1'b1; tick();
    chk("R4 ring feedback", {31'b0, elem_out[8]}, 32'h1);
    gpio_in[7] = 1'b0; #1 chk("R4 ring is state", {31'b0, elem_out[8]}, 32'h1);
    tick(); chk("R4 ring follows", {31'b0, elem_out[8]}, 32'h0);

    // R5: element 14 wraps to gpio_in[0]
    wr(6'd14, cw(2'd0, 2'd0, 1'b0, 1'b1, 4'b1010, 1'b0));
    gpio_in[0] = 1'b1; #1 chk("R5 gpio wrap high", {31'b0, elem_out[14]}, 32'h1);
    gpio_in[0] = 1'b0; #1 chk("R5 gpio wrap low", {31'b0, elem_out[14]}, 32'h0);

    // R6 and R9: element 17 follows element 1
    wr(6'd1, cw(2'd0, 2'd0, 1'b0, 1'b1, 4'b1010, 1'b0));
    wr(6'd17, cw(2'd0, 2'd0, 1'b0, 1'b1, 4'b1010, 1'b0));
    gpio_in[1] = 1'b1; #1
    chk("R6 lower-half source high", {31'b0, elem_out[17]}, 32'h1);
    chk("R9 gpio_out[1] high", {31'b0, gpio_out[1]}, 32'h1);
    addr = 6'd33; #1 chk("R8 status bits", {30'b0, rdata[17], rdata[1]}, 32'h3);
    gpio_in[1] = 1'b0; #1
    chk("R6 lower-half source low", {31'b0, elem_out[17]}, 32'h0);
    chk("R9 gpio_out[1] low", {31'b0, gpio_out[1]}, 32'h0);
    wr(6'd17, cw(2'd0, 2'd0, 1'b1, 1'b1, 4'b0101, 1'b0));
    gpio_in[1] = 1'b1; #1 chk("R6 open leg reads 0", {31'b0, elem_out[17]}, 32'h1);

    // R7: registered inverter of own state
    wr(6'd4, cw(2'd0, 2'd0, 1'b0, 1'b0, 4'b0101, 1'b1));
    chk("R7 toggle start", {31'b0, elem_out[4]}, 32'h0);
    tick(); chk("R7 toggle 1", {31'b0, elem_out[4]}, 32'h1);
    tick(); chk("R7 toggle 2", {31'b0, elem_out[4]}, 32'h0);

    // R8: register port
    addr = 6'd4; #1 chk("R8 cfg readback", rdata, 32'h0000000B);
    wr(6'd32, 32'hFFFF_0004);
    addr = 6'd32; #1 chk("R8 data readback", rdata, 32'h00000004);
    wr(6'd40, 32'hFFFF_FFFF);
    addr = 6'd5; #1 chk("R8 unmapped cfg kept", rdata, 32'h0);
    addr = 6'd32; #1 chk("R8 unmapped data kept", rdata, 32'h00000004);
    addr = 6'd40; #1 chk("R8 unmapped reads 0", rdata, 32'h0);
    chk("R8 unmapped outputs kept", {31'b0, elem_out[5]}, 32'h0);

    // R5 data path and R3 registered delay on element 2
    wr(6'd2, cw(2'd0, 2'd0, 1'b1, 1'b1, 4'b1010, 1'b0));
    chk("R5 data bit", {31'b0, elem_out[2]}, 32'h1);
    wr(6'd2, cw(2'd0, 2'd0, 1'b1, 1'b1, 4'b1010, 1'b1));
    chk("R3 registered on", {31'b0, elem_out[2]}, 32'h1);
    wr(6'd32, 32'h0);
    chk("R3 registered holds", {31'b0, elem_out[2]}, 32'h1);
    tick(); chk("R3 registered updates", {31'b0, elem_out[2]}, 32'h0);

    // R10: rewrite during capture
    wr(6'd5, cw(2'd0, 2'd0, 1'b0, 1'b0, 4'b1111, 1'b1));
    chk("R10 first capture old", {31'b0, elem_out[5]}, 32'h0);
    tick(); chk("R10 const one", {31'b0, elem_out[5]}, 32'h1);
    wr(6'd5, cw(2'd0, 2'd0, 1'b0, 1'b0, 4'b0000, 1'b1));
    chk("R10 old word at write edge", {31'b0, elem_out[5]}, 32'h1);
    tick(); chk("R10 new word next edge", {31'b0, elem_out[5]}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule